// File: doc/BRIEF.md
# Power-On Strap Latch Sequencer

This block sequences a group of dual-purpose pins that read configuration straps when power comes up and drive clock outputs afterwards. While power-good is high, a counter clocked by the crystal reference keeps every pin driver three-stated for a fixed window. During that time the external pull resistors set each pad level. The last cycle of the window captures the five pad levels into a strap register. On the next reference cycle all five drivers turn on together and a ready flag rises.

The strap register holds four frequency-select bits, which pick the synthesizer's frequency table entry, and one mode bit. The mode bit decides what a shared pin does. When it is 1, the pin drives a reference clock. When it is 0, the pin is an input that stops the PCI clocks. Power-good is the only thing that clears the straps and restarts the window. No other reset reaches this block.

Top module: `strap_seq`

## Requirements
- R1: While `pwr_ok` is low, every rising edge of `clk_ref` leaves `strap_fs`, `strap_mode`, `drv_en`, `ready`, `ref_out_en` and `stop_in_sel` at 0.
- R2: Counting the first rising edge with `pwr_ok` high as edge 1, `drv_en` stays 0 and `ready` stays 0 through edge `WIN_CYCLES`. This three-states all five drivers for the whole window.
- R3: Edge `WIN_CYCLES` captures the pad levels: `strap_fs` takes `pin_lvl[3:0]` and `strap_mode` takes `pin_lvl[4]` (1 = pulled up, 0 = pulled down). Pad levels seen earlier in the window have no effect.
- R4: Edge `WIN_CYCLES`+1, one cycle after the capture, sets all five `drv_en` bits and `ready`. They then stay set while `pwr_ok` stays high.
- R5: `drv_en` is either all zeros or all ones, and `ready` is 1 exactly when `drv_en` is all ones.
- R6: Once captured, `strap_fs` and `strap_mode` do not follow later changes on `pin_lvl` for as long as `pwr_ok` stays high.
- R7: If `pwr_ok` falls before the window ends, the window restarts from zero when `pwr_ok` rises again. Capture then happens `WIN_CYCLES` edges after the new rise.
- R8: With `ready` high, `strap_mode`=1 gives `ref_out_en`=1 and `stop_in_sel`=0, and `strap_mode`=0 gives `ref_out_en`=0 and `stop_in_sel`=1. Both are 0 while `ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Crystal reference clock that paces the window |
| pwr_ok | input | 1 | Supply-above-threshold flag; low acts as the synchronous clear |
| pin_lvl | input | 5 | Pad levels: bits 3:0 frequency select, bit 4 mode |
| strap_fs | output | 4 | Latched frequency-select bits |
| strap_mode | output | 1 | Latched mode bit |
| drv_en | output | 5 | Output driver enables for the five pads |
| ready | output | 1 | Straps latched and drivers running |
| ref_out_en | output | 1 | Shared pin drives the reference clock |
| stop_in_sel | output | 1 | Shared pin acts as the PCI stop input |

## Verification
On every cycle, the assertions check the following:
- the clear state while power-good is low;
- that ready tracks a count of edges since power-good rose;
- that the enables are all-or-none;
- that the straps are frozen once ready is set;
- that the shared pin never has both roles at once.

They also check that the value held in the cycle after capture equals the pad levels one edge earlier. Only the bench scenarios can show the rest:
- that pad values changed late in the window, rather than early ones, are the ones kept;
- that an aborted window restarts with its full length;
- that each mode value gives the matching shared-pin role across several strap patterns.

// File: rtl/strap_pkg.sv
// Package: shared types for the strap latch sequencer.
// Assumes four frequency-select pads plus one mode pad.
package strap_pkg;

    localparam int FS_W   = 4;
    localparam int PAD_N  = FS_W + 1;

    // Sequencer phase after power-good rises
    typedef enum logic [1:0] {
        PH_WINDOW = 2'd0,
        PH_LATCH  = 2'd1,
        PH_DRIVE  = 2'd2
    } phase_t;

    // Latched strap image: mode sits above the frequency bits
    typedef struct packed {
        logic            mode;
        logic [FS_W-1:0] fs;
    } strap_t;

endpackage

// File: rtl/strap_window_timer.sv
// Module: counts reference cycles of the three-state window.
// Assumes WIN_CYCLES >= 2; pwr_ok low clears the count synchronously.
// win_end is high in the last window cycle while run is high.
module strap_window_timer #(
    parameter int WIN_CYCLES = 28636,
    localparam int CW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1
) (
    input  logic clk,
    input  logic pwr_ok,
    input  logic run,
    output logic win_end
);

    logic [CW-1:0] count;
    logic          at_last;

    // Flag the terminal count
    always_comb at_last = (count == CW'(WIN_CYCLES - 1));

    // Advance the count while the window runs
    always_ff @(posedge clk) begin
        if (!pwr_ok)
            count <= '0;
        else if (run && !at_last)
            count <= count + 1'b1;
    end

    // Window end is only meaningful while running
    always_comb win_end = run && at_last;

endmodule

// File: rtl/strap_phase_fsm.sv
// Module: steps window -> latch -> drive after power-good.
// Assumes pwr_ok is the only clear; it restarts the sequence.
module strap_phase_fsm
    import strap_pkg::*;
(
    input  logic clk,
    input  logic pwr_ok,
    input  logic win_end,
    output logic in_window,
    output logic capture_en,
    output logic drive_on
);

    phase_t phase, phase_nx;

    // Next-phase selection
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_WINDOW: if (win_end) phase_nx = PH_LATCH;
            PH_LATCH:  phase_nx = PH_DRIVE;
            PH_DRIVE:  phase_nx = PH_DRIVE;
            default:   phase_nx = PH_WINDOW;
        endcase
    end

    // Phase register, cleared by loss of power-good
    always_ff @(posedge clk) begin
        if (!pwr_ok)
            phase <= PH_WINDOW;
        else
            phase <= phase_nx;
    end

    // Decoded controls for timer, latch and drivers
    always_comb begin
        in_window  = (phase == PH_WINDOW);
        capture_en = in_window && win_end;
        drive_on   = (phase == PH_DRIVE);
    end

endmodule

// File: rtl/strap_capture_latch.sv
// Module: holds the pad levels sampled at the end of the window.
// Assumes capture_en pulses once per power-up; pwr_ok low clears.
module strap_capture_latch
    import strap_pkg::*;
(
    input  logic             clk,
    input  logic             pwr_ok,
    input  logic             capture_en,
    input  logic [PAD_N-1:0] pin_lvl,
    output strap_t           strap
);

    // Capture the pad image once and then hold it
    always_ff @(posedge clk) begin
        if (!pwr_ok)
            strap <= '0;
        else if (capture_en)
            strap <= strap_t'(pin_lvl);
    end

endmodule

// File: rtl/strap_drive_ctrl.sv
// Module: fans the drive phase out to pad enables and the shared-pin role.
// Assumes drive_on is only high after the straps are stable.
module strap_drive_ctrl #(
    parameter int N_PADS = 5
) (
    input  logic              drive_on,
    input  logic              mode,
    output logic [N_PADS-1:0] drv_en,
    output logic              ready,
    output logic              ref_out_en,
    output logic              stop_in_sel
);

    // One enable per pad, all tied to the drive phase
    for (genvar g = 0; g < N_PADS; g++) begin : g_pad_en
        always_comb drv_en[g] = drive_on;
    end

    // Ready flag and shared-pin role selection
    always_comb begin
        ready       = drive_on;
        ref_out_en  = drive_on && mode;
        stop_in_sel = drive_on && !mode;
    end

endmodule

// File: rtl/strap_seq.sv
// Module: top of the power-on strap latch sequencer.
// Assumes clk_ref is the crystal reference and runs whenever pwr_ok is high.
// Pads three-state for WIN_CYCLES edges, latch, then drive one edge later.
module strap_seq
    import strap_pkg::*;
#(
    parameter int WIN_CYCLES = 28636
) (
    input  logic             clk_ref,
    input  logic             pwr_ok,
    input  logic [PAD_N-1:0] pin_lvl,
    output logic [FS_W-1:0]  strap_fs,
    output logic             strap_mode,
    output logic [PAD_N-1:0] drv_en,
    output logic             ready,
    output logic             ref_out_en,
    output logic             stop_in_sel
);

    logic   in_window;
    logic   win_end;
    logic   capture_en;
    logic   drive_on;
    strap_t strap;

    strap_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
        .clk     (clk_ref),
        .pwr_ok  (pwr_ok),
        .run     (in_window),
        .win_end (win_end)
    );

    strap_phase_fsm u_fsm (
        .clk        (clk_ref),
        .pwr_ok     (pwr_ok),
        .win_end    (win_end),
        .in_window  (in_window),
        .capture_en (capture_en),
        .drive_on   (drive_on)
    );

    strap_capture_latch u_latch (
        .clk        (clk_ref),
        .pwr_ok     (pwr_ok),
        .capture_en (capture_en),
        .pin_lvl    (pin_lvl),
        .strap      (strap)
    );

    strap_drive_ctrl #(.N_PADS(PAD_N)) u_drv (
        .drive_on    (drive_on),
        .mode        (strap.mode),
        .drv_en      (drv_en),
        .ready       (ready),
        .ref_out_en  (ref_out_en),
        .stop_in_sel (stop_in_sel)
    );

    // Expose the latched image
    always_comb begin
        strap_fs   = strap.fs;
        strap_mode = strap.mode;
    end

endmodule

// File: rtl/strap_seq_chk.sv
// Module: assertion checker bound to strap_seq.
// Keeps its own count of edges since power-good rose.
module strap_seq_chk #(
    parameter int WIN_CYCLES = 28636,
    localparam int KW = $clog2(WIN_CYCLES + 2)
) (
    input logic       clk_ref,
    input logic       pwr_ok,
    input logic [4:0] pin_lvl,
    input logic [3:0] strap_fs,
    input logic       strap_mode,
    input logic [4:0] drv_en,
    input logic       ready,
    input logic       ref_out_en,
    input logic       stop_in_sel
);

    logic          armed = 1'b0;
    logic [KW-1:0] edges;

    // Mark that at least one edge has passed
    always_ff @(posedge clk_ref) armed <= 1'b1;

    // Saturating count of high power-good edges
    always_ff @(posedge clk_ref) begin
        if (!pwr_ok)
            edges <= '0;
        else if (edges != KW'(WIN_CYCLES + 1))
            edges <= edges + 1'b1;
    end

    // R1: a power-good low edge leaves everything cleared
    a_r1_clear_when_off: assert property (@(posedge clk_ref) disable iff (!armed)
        !$past(pwr_ok) |-> (drv_en == '0 && !ready && strap_fs == '0 &&
                            !strap_mode && !ref_out_en && !stop_in_sel));

    // R2, R4: ready exactly after WIN_CYCLES+1 high edges
    a_r2_window_length: assert property (@(posedge clk_ref) disable iff (!pwr_ok)
        ready == (edges == KW'(WIN_CYCLES + 1)));

    // R3: value held after the capture edge equals the pads at that edge
    a_r3_capture_value: assert property (@(posedge clk_ref) disable iff (!pwr_ok)
        (edges == KW'(WIN_CYCLES)) |-> ({strap_mode, strap_fs} == $past(pin_lvl)));

    // R5: enables are all-or-none and match ready
    a_r5_enables_together: assert property (@(posedge clk_ref) disable iff (!pwr_ok)
        (drv_en == '0 || drv_en == '1) && (ready == (drv_en == '1)));

    // R4: ready stays set while power holds
    a_r4_ready_sticky: assert property (@(posedge clk_ref) disable iff (!pwr_ok)
        ready |=> ready);

    // R6: straps frozen once ready
    a_r6_strap_frozen: assert property (@(posedge clk_ref) disable iff (!pwr_ok)
        ready |=> $stable({strap_mode, strap_fs}));

    // R8: shared pin has exactly one role when ready, none otherwise
    a_r8_shared_role: assert property (@(posedge clk_ref) disable iff (!pwr_ok)
        $countones({ref_out_en, stop_in_sel}) == (ready ? 1 : 0));

    // R8: role follows the mode bit
    a_r8_role_by_mode: assert property (@(posedge clk_ref) disable iff (!pwr_ok)
        ready |-> (ref_out_en == strap_mode));

endmodule

bind strap_seq strap_seq_chk #(.WIN_CYCLES(WIN_CYCLES)) u_chk (
    .clk_ref     (clk_ref),
    .pwr_ok      (pwr_ok),
    .pin_lvl     (pin_lvl),
    .strap_fs    (strap_fs),
    .strap_mode  (strap_mode),
    .drv_en      (drv_en),
    .ready       (ready),
    .ref_out_en  (ref_out_en),
    .stop_in_sel (stop_in_sel)
);

// File: tb/strap_seq_tb.sv
// Scoreboard bench: tasks queue expected outputs per edge, a monitor compares.
module strap_seq_tb;

    localparam int WIN = 40;

    typedef struct {
        int          cyc;
        logic [12:0] exp;   // {mode, fs[3:0], drv_en[4:0], ready, ref, stop}
        string       tag;
    } item_t;

    logic       clk_ref = 1'b0;
    logic       pwr_ok  = 1'b0;
    logic [4:0] pin_lvl = 5'b0;
    logic [3:0] strap_fs;
    logic       strap_mode;
    logic [4:0] drv_en;
    logic       ready;
    logic       ref_out_en;
    logic       stop_in_sel;

    int    cyc    = 0;
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    item_t sb[$];

    strap_seq #(.WIN_CYCLES(WIN)) u_dut (
        .clk_ref     (clk_ref),
        .pwr_ok      (pwr_ok),
        .pin_lvl     (pin_lvl),
        .strap_fs    (strap_fs),
        .strap_mode  (strap_mode),
        .drv_en      (drv_en),
        .ready       (ready),
        .ref_out_en  (ref_out_en),
        .stop_in_sel (stop_in_sel)
    );

    always #5 clk_ref = ~clk_ref;
    always @(posedge clk_ref) cyc <= cyc + 1;

    function automatic logic [12:0] pack_exp(logic [4:0] st, logic drv);
        return {st, {5{drv}}, drv, drv & st[4], drv & ~st[4]};
    endfunction

    task automatic expect_at(int at, logic [12:0] e, string tag);
        item_t it;
        it.cyc = at; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    // Compare queued expectations in the middle of the low phase
    always @(negedge clk_ref) begin
        logic [12:0] act;
        act = {strap_mode, strap_fs, drv_en, ready, ref_out_en, stop_in_sel};
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (it.cyc != cyc || act !== it.exp) begin
                fails++;
                $display("FAIL %s cyc=%0d actual=%b expected=%b", it.tag, cyc, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk_ref); #2;
    endtask

    // Full power-up; pads hold junk until the last window cycle
    task automatic power_up(logic [4:0] st);
        int p0;
        pin_lvl = ~st;
        step();
        p0 = cyc;
        pwr_ok = 1'b1;
        expect_at(p0 + WIN - 1, pack_exp(5'b0, 1'b0), "R2 still three-stated");
        repeat (WIN - 1) step();
        pin_lvl = st;
        expect_at(p0 + WIN,     pack_exp(st, 1'b0), "R3 captured, drivers off");
        expect_at(p0 + WIN + 1, pack_exp(st, 1'b1), "R4 R5 R8 drivers on");
        repeat (3) step();
        pin_lvl = ~st;
        expect_at(cyc + 3, pack_exp(st, 1'b1), "R6 pads ignored");
        repeat (5) step();
    endtask

    task automatic power_down();
        step();
        pwr_ok = 1'b0;
        expect_at(cyc + 1, pack_exp(5'b0, 1'b0), "R1 cleared on power loss");
        repeat (3) step();
    endtask

    initial begin
        repeat (2) step();
        expect_at(cyc + 1, pack_exp(5'b0, 1'b0), "R1 reset state");
        repeat (2) step();

        power_up(5'b1_1010);
        power_down();

        // R7: abort the window half way, then run a full one
        pin_lvl = 5'b1_1111;
        step();
        pwr_ok = 1'b1;
        expect_at(cyc + WIN / 2, pack_exp(5'b0, 1'b0), "R7 mid-window no drive");
        repeat (WIN / 2) step();
        power_down();
        power_up(5'b0_0101);
        power_down();
        power_up(5'b1_1111);
        power_down();
        power_up(5'b0_0000);
        repeat (4) step();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_ref);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule